// File: doc/BRIEF.md
# Shared Watchdog and Wakeup Timer Controller

This block runs one tick counter that acts either as a watchdog or as a periodic wakeup timer. Its count source is a slow oscillator. The raw oscillator tick is brought into the system clock domain through a two-flop synchronizer and a rising-edge detector. Each detected edge advances the counter while the block is in its counting state. When the count reaches the selected terminal value, an overflow occurs and the counter wraps to zero. If the watchdog enable is set, the overflow becomes a one-cycle system-reset request. Otherwise it sets a sticky timeout interrupt, which stays set until it is acknowledged.

A four-state controller decides whether the oscillator runs and what the counter does. It reads the sleep flag and two enable bits: the watchdog enable, and the wakeup enable, which also keeps the timer alive during sleep. The states are:

- ST_STOP: awake with both enables low. The oscillator is off and the count is held.
- ST_RUN: counting, with the oscillator on.
- ST_PARK: asleep with both enables low. The oscillator is off and the count is held.
- ST_FLUSH: asleep with the watchdog enable high and the wakeup enable low. The oscillator is off and the count is forced to zero.

In every cycle the next state is chosen from the mode table, from any current state. The transitions are:

- start: to ST_RUN.
- halt: ST_RUN to ST_STOP.
- park: to ST_PARK.
- flush: to ST_FLUSH.
- wake: ST_PARK or ST_FLUSH back to ST_RUN.

Software restarts the count with a clear strobe. A 2-bit period select picks one of four terminal counts. The chosen setting is captured only when the counter clears or overflows.

Top module: `wkt_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, rst_req, irq and osc_en are 0. Reset also zeroes the count and makes period setting 0 active.
- R2: When awake (sleep=0), osc_en becomes 1 one clock after the inputs change, unless rst_en=0 and wake_en=0 at once, in which case osc_en becomes 0.
- R3: When asleep (sleep=1), osc_en equals wake_en one clock later, whatever rst_en is.
- R4: Counting works only while osc_en=1. Each rising edge of osc_tick advances the count by one. The TC-th edge after a clear is an overflow, which returns the count to 0, so overflows repeat every TC edges.
- R5: A period_sel value of 0, 1, 2 or 3 selects terminal count TC0, TC1, TC2 or TC3. A new value takes effect only from the next clear or overflow.
- R6: A one-cycle pulse on sw_clr returns the count to zero, so the next overflow comes a full TC edges after it.
- R7: When rst_en=1, an overflow raises rst_req for exactly one clock and leaves irq unchanged.
- R8: When rst_en=0, an overflow sets irq. irq stays at 1 until irq_ack is high for a cycle. If an overflow and irq_ack arrive together, irq stays set.
- R9: When asleep with rst_en=0 and wake_en=0, edges of osc_tick are ignored and the count is kept. Counting resumes from the kept count after waking.
- R10: When asleep with rst_en=1 and wake_en=0, the count is forced to zero and held there.
- R11: With rst_en=1 and wake_en=1, counting continues across sleep entry and exit without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Raw slow-oscillator tick, asynchronous |
| sw_clr | input | 1 | Software clear strobe |
| sleep | input | 1 | Sleep-mode flag |
| rst_en | input | 1 | Watchdog (reset) enable |
| wake_en | input | 1 | Wakeup interrupt / sleep keepalive enable |
| period_sel | input | 2 | Period setting, 0 to 3 |
| irq_ack | input | 1 | Timeout interrupt acknowledge |
| rst_req | output | 1 | One-cycle system-reset request |
| irq | output | 1 | Sticky timeout interrupt flag |
| osc_enable | output | 1 | Oscillator enable |

The enable output is named osc_en throughout the requirements.

## Verification
A wrong controller state shows up on osc_en one clock after the mode inputs change. A freeze that should have been a clear, or the reverse, shows only later, as an overflow that arrives some oscillator edges early or late after waking. A count error, or a period setting latched at the wrong time, shifts the overflow by whole tick edges. The bench exposes such errors by counting edges exactly up to one edge before the expected overflow and then one edge past it. Misrouting an overflow appears within two clocks of the last synchronized edge, as a wrong irq value or a wrong rst_req pulse count.

// File: rtl/wkt_pkg.sv
package wkt_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,   // awake, both enables low: oscillator off, count held
        ST_RUN   = 2'd1,   // counting
        ST_PARK  = 2'd2,   // asleep, both enables low: count held
        ST_FLUSH = 2'd3    // asleep, watchdog on, keepalive off: count cleared
    } wkt_state_e;

    // Width needed to hold values up to max_val
    function automatic int cnt_width(input int max_val);
        int w;
        w = 1;
        while ((1 << w) <= max_val) begin
            w = w + 1;
        end
        return w;
    endfunction

endpackage

// File: rtl/wkt_tick_sync.sv
module wkt_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_raw,
    output logic tick_pulse
);

    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        chain[g] <= 1'b0;
                    end else begin
                        chain[g] <= tick_raw;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        chain[g] <= 1'b0;
                    end else begin
                        chain[g] <= chain[g-1];
                    end
                end
            end
        end
    endgenerate

    // Previous synchronized level, for edge detect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= chain[STAGES-1];
        end
    end

    assign tick_pulse = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/wkt_mode_fsm.sv
module wkt_mode_fsm
    import wkt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep,
    input  logic       rst_en,
    input  logic       wake_en,
    output wkt_state_e state,
    output logic       osc_en,
    output logic       cnt_run,
    output logic       cnt_flush
);

    wkt_state_e state_q;
    wkt_state_e state_d;
    wkt_state_e target;

    // Mode table: which state the inputs call for
    always_comb begin
        if (!sleep) begin
            target = (rst_en || wake_en) ? ST_RUN : ST_STOP;
        end else if (wake_en) begin
            target = ST_RUN;
        end else if (rst_en) begin
            target = ST_FLUSH;
        end else begin
            target = ST_PARK;
        end
    end

    // Next-state selection with named transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: begin
                // start, park, flush
                state_d = target;
            end
            ST_RUN: begin
                // halt, park, flush
                state_d = target;
            end
            ST_PARK: begin
                // wake, flush, or stay parked
                state_d = target;
            end
            ST_FLUSH: begin
                // wake, park, or stay flushed
                state_d = target;
            end
            default: begin
                state_d = ST_STOP;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from state
    always_comb begin
        osc_en    = 1'b0;
        cnt_run   = 1'b0;
        cnt_flush = 1'b0;
        unique case (state_q)
            ST_STOP:  ;
            ST_RUN: begin
                osc_en  = 1'b1;
                cnt_run = 1'b1;
            end
            ST_PARK:  ;
            ST_FLUSH: cnt_flush = 1'b1;
            default:  ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/wkt_counter.sv
module wkt_counter #(
    parameter int TC0   = 14,
    parameter int TC1   = 28,
    parameter int TC2   = 69,
    parameter int TC3   = 138,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             clr,
    input  logic [1:0]       period_sel,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    logic [1:0]       sel_act;
    logic [CNT_W-1:0] term;

    // Last count value before wrap, for the active setting
    always_comb begin
        unique case (sel_act)
            2'd0: term = CNT_W'(TC0 - 1);
            2'd1: term = CNT_W'(TC1 - 1);
            2'd2: term = CNT_W'(TC2 - 1);
            2'd3: term = CNT_W'(TC3 - 1);
            default: term = CNT_W'(TC0 - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            sel_act <= 2'd0;
            ovf     <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (clr) begin
                cnt     <= '0;
                sel_act <= period_sel;
            end else if (tick && run) begin
                if (cnt >= term) begin
                    cnt     <= '0;
                    ovf     <= 1'b1;
                    sel_act <= period_sel;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wkt_route.sv
module wkt_route (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic rst_en,
    input  logic irq_ack,
    output logic rst_req,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req <= 1'b0;
            irq     <= 1'b0;
        end else begin
            rst_req <= ovf & rst_en;
            if (ovf && !rst_en) begin
                irq <= 1'b1;
            end else if (irq_ack) begin
                irq <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wkt_ctrl.sv
module wkt_ctrl
    import wkt_pkg::*;
#(
    parameter int TC0         = 14,
    parameter int TC1         = 28,
    parameter int TC2         = 69,
    parameter int TC3         = 138,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       sw_clr,
    input  logic       sleep,
    input  logic       rst_en,
    input  logic       wake_en,
    input  logic [1:0] period_sel,
    input  logic       irq_ack,
    output logic       rst_req,
    output logic       irq,
    output logic       osc_enable
);

    localparam int TC_MAX01 = (TC0 > TC1) ? TC0 : TC1;
    localparam int TC_MAX23 = (TC2 > TC3) ? TC2 : TC3;
    localparam int TC_MAX   = (TC_MAX01 > TC_MAX23) ? TC_MAX01 : TC_MAX23;
    localparam int CNT_W    = cnt_width(TC_MAX);

    logic             tick_pulse;
    wkt_state_e       state;
    logic             cnt_run;
    logic             cnt_flush;
    logic             cnt_clr;
    logic [CNT_W-1:0] cnt;
    logic             ovf;

    wkt_tick_sync #(
        .STAGES(SYNC_STAGES)
    ) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_raw  (osc_tick),
        .tick_pulse(tick_pulse)
    );

    wkt_mode_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep    (sleep),
        .rst_en   (rst_en),
        .wake_en  (wake_en),
        .state    (state),
        .osc_en   (osc_enable),
        .cnt_run  (cnt_run),
        .cnt_flush(cnt_flush)
    );

    assign cnt_clr = sw_clr | cnt_flush;

    wkt_counter #(
        .TC0  (TC0),
        .TC1  (TC1),
        .TC2  (TC2),
        .TC3  (TC3),
        .CNT_W(CNT_W)
    ) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_pulse),
        .run       (cnt_run),
        .clr       (cnt_clr),
        .period_sel(period_sel),
        .cnt       (cnt),
        .ovf       (ovf)
    );

    wkt_route i_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .ovf    (ovf),
        .rst_en (rst_en),
        .irq_ack(irq_ack),
        .rst_req(rst_req),
        .irq    (irq)
    );

endmodule

// File: rtl/wkt_ctrl_chk.sv
module wkt_ctrl_chk
    import wkt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep,
    input logic             rst_en,
    input logic             wake_en,
    input logic             irq_ack,
    input logic             rst_req,
    input logic             irq,
    input logic             osc_enable,
    input logic             tick_pulse,
    input logic             cnt_clr,
    input wkt_state_e       state,
    input logic [CNT_W-1:0] cnt
);

    // R7
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R7
    rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(rst_en));

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(!rst_en));

    // R3
    sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sleep && !wake_en)) |-> !osc_enable);

    // R4
    cnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_pulse && !cnt_clr) |=> $stable(cnt));

    // R10
    flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(state == ST_FLUSH)) |-> (cnt == '0));

endmodule

bind wkt_ctrl wkt_ctrl_chk #(.CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep     (sleep),
    .rst_en    (rst_en),
    .wake_en   (wake_en),
    .irq_ack   (irq_ack),
    .rst_req   (rst_req),
    .irq       (irq),
    .osc_enable(osc_enable),
    .tick_pulse(tick_pulse),
    .cnt_clr   (cnt_clr),
    .state     (state),
    .cnt       (cnt)
);

// File: tb/test_wkt_ctrl.sv
module test_wkt_ctrl;

    localparam int TC0 = 4;
    localparam int TC1 = 6;
    localparam int TC2 = 8;
    localparam int TC3 = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       sw_clr = 1'b0;
    logic       sleep = 1'b0;
    logic       rst_en = 1'b0;
    logic       wake_en = 1'b1;
    logic [1:0] period_sel = 2'd0;
    logic       irq_ack = 1'b0;
    logic       rst_req;
    logic       irq;
    logic       osc_enable;

    int checks = 0;
    int errors = 0;
    int rst_pulses = 0;
    int rst_run = 0;
    int rst_run_max = 0;

    always #2 clk = ~clk;

    wkt_ctrl #(
        .TC0(TC0), .TC1(TC1), .TC2(TC2), .TC3(TC3)
    ) i_wkt_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .sw_clr    (sw_clr),
        .sleep     (sleep),
        .rst_en    (rst_en),
        .wake_en   (wake_en),
        .period_sel(period_sel),
        .irq_ack   (irq_ack),
        .rst_req   (rst_req),
        .irq       (irq),
        .osc_enable(osc_enable)
    );

    // Reset request pulse monitor
    always @(posedge clk) begin
        if (rst_req) begin
            rst_pulses = (rst_run == 0) ? rst_pulses + 1 : rst_pulses;
            rst_run = rst_run + 1;
            if (rst_run > rst_run_max) rst_run_max = rst_run;
        end else begin
            rst_run = 0;
        end
    end

    // {sleep, rst_en, wake_en, expected osc_enable}
    localparam logic [3:0] MODE_VEC [8] = '{
        4'b0000, 4'b0011, 4'b0101, 4'b0111,
        4'b1000, 4'b1011, 4'b1100, 4'b1111
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            osc_tick = 1'b1;
            cycles(4);
            osc_tick = 1'b0;
            cycles(4);
        end
    endtask

    task automatic clear_pulse();
        sw_clr = 1'b1;
        cycles(1);
        sw_clr = 1'b0;
        cycles(1);
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        cycles(1);
        irq_ack = 1'b0;
        cycles(1);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        int p0;
        cycles(4);
        // R1 reset state
        chk("R1 rst_req", rst_req, 0);
        chk("R1 irq", irq, 0);
        chk("R1 osc_enable", osc_enable, 0);
        rst_n = 1'b1;
        cycles(2);

        // R2 / R3 mode table
        for (int i = 0; i < 8; i++) begin
            sleep   = MODE_VEC[i][3];
            rst_en  = MODE_VEC[i][2];
            wake_en = MODE_VEC[i][1];
            cycles(2);
            chk(MODE_VEC[i][3] ? "R3 osc_enable" : "R2 osc_enable",
                osc_enable, int'(MODE_VEC[i][0]));
        end
        sleep = 1'b0; rst_en = 1'b0; wake_en = 1'b1;
        cycles(2);

        // R4 / R8 overflow, sticky, wrap
        clear_pulse();
        ticks(TC0 - 1);
        chk("R4 irq before overflow", irq, 0);
        ticks(1);
        chk("R4 irq at overflow", irq, 1);
        ticks(2);
        chk("R8 irq sticky", irq, 1);
        ack_pulse();
        chk("R8 irq acked", irq, 0);
        ticks(1);
        chk("R4 wrap before", irq, 0);
        ticks(1);
        chk("R4 wrap repeat", irq, 1);

        // R6 software clear
        ack_pulse();
        clear_pulse();
        ticks(TC0 - 1);
        clear_pulse();
        ticks(TC0 - 1);
        chk("R6 irq after clear", irq, 0);
        ticks(1);
        chk("R6 irq full period", irq, 1);

        // R5 period selection latched at clear/overflow
        ack_pulse();
        clear_pulse();
        period_sel = 2'd2;
        ticks(TC0);
        chk("R5 old period kept", irq, 1);
        ack_pulse();
        ticks(TC2 - 1);
        chk("R5 new period early", irq, 0);
        ticks(1);
        chk("R5 new period TC2", irq, 1);
        period_sel = 2'd3;
        clear_pulse();
        ack_pulse();
        ticks(TC3 - 1);
        chk("R5 TC3 early", irq, 0);
        ticks(1);
        chk("R5 TC3", irq, 1);
        period_sel = 2'd1;
        clear_pulse();
        ack_pulse();
        ticks(TC1 - 1);
        chk("R5 TC1 early", irq, 0);
        ticks(1);
        chk("R5 TC1", irq, 1);

        // R9 park: count frozen through sleep
        period_sel = 2'd0;
        clear_pulse();
        ack_pulse();
        ticks(2);
        sleep = 1'b1; wake_en = 1'b0;
        cycles(2);
        ticks(5);
        chk("R9 irq in park", irq, 0);
        sleep = 1'b0; wake_en = 1'b1;
        cycles(2);
        ticks(1);
        chk("R9 resumed early", irq, 0);
        ticks(1);
        chk("R9 resumed overflow", irq, 1);

        // R10 / R7 flush and watchdog reset
        ack_pulse();
        rst_en = 1'b1;
        clear_pulse();
        p0 = rst_pulses;
        ticks(2);
        sleep = 1'b1; wake_en = 1'b0;
        cycles(2);
        ticks(3);
        sleep = 1'b0; wake_en = 1'b1;
        cycles(2);
        ticks(TC0 - 1);
        chk("R10 no reset after flush", rst_pulses, p0);
        ticks(1);
        chk("R10 reset after full period", rst_pulses, p0 + 1);
        chk("R7 irq untouched", irq, 0);
        chk("R7 pulse width", rst_run_max, 1);

        // R11 counting through sleep
        clear_pulse();
        p0 = rst_pulses;
        ticks(2);
        sleep = 1'b1;
        cycles(2);
        ticks(1);
        chk("R11 early", rst_pulses, p0);
        ticks(1);
        chk("R11 overflow in sleep", rst_pulses, p0 + 1);
        sleep = 1'b0;
        cycles(2);

        summary();
        $finish;
    end

endmodule